// File: doc/BRIEF.md
# Access-Steered Bidirectional I/O Port

This block is a small general-purpose I/O port whose pins are driven, released and sampled by single-cycle access commands from a host sequencer. In its default variant there is no direction register for software to manage: every read-type access turns the whole port around to input, and every write-type access turns it around to output while it updates the output latch on the same clock edge. All pins always point the same way.

A parameter selects a second variant in which each pin's direction is held separately and changes only through a dedicated direction-write command. Read and write accesses then leave direction alone. In both variants a standby input releases every driver at once and masks the sampled pins to zero. The pad is modelled as three vectors: output data, output enable and input data.

Commands arrive as a valid strobe with a 3-bit code and a data/mask vector. The read result and the test flag are registered. They keep their value until the next access of the same kind.

Top module: `auto_dir_port`

## Requirements
- R1: After reset, pad_oe, pad_out, rd_data and test_flag are all zero.
- R2: In the auto variant (PER_PIN=0), a read (code 1), test-set (code 2) or test-clear (code 3) access makes every pin an input from the next clock edge. It leaves pad_out unchanged.
- R3: In the auto variant, a write (code 4), bit-set (code 5) or bit-clear (code 6) access makes every pin an output on the same edge that updates the latch.
- R4: A write loads acc_data into the output latch. A bit-set ORs acc_data into the latch as a mask. A bit-clear clears the latch bits where acc_data is 1.
- R5: In the auto variant, pad_oe is always all zeros or all ones, and a direction-write (code 7) changes neither direction nor latch.
- R6: In the per-pin variant (PER_PIN=1), a direction-write loads acc_data as the per-pin output enable (1 = output). Read, test and write-type accesses leave the direction unchanged.
- R7: A read captures the qualified pin values into rd_data one edge later. rd_data holds until the next read.
- R8: A test-set returns test_flag=1 when every pin selected by acc_data reads 1. A test-clear returns 1 when every selected pin reads 0. An empty mask gives 1. The flag holds until the next test.
- R9: While standby is high, pad_oe is zero in the same cycle. The stored direction is kept, and the enables return when standby falls.
- R10: While standby is high, sampled pin values are taken as zero for reads and tests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Releases all drivers and masks inputs |
| acc_valid | input | 1 | Access strobe, one command per cycle |
| acc_op | input | 3 | Access code (1 read, 2 test-set, 3 test-clear, 4 write, 5 bit-set, 6 bit-clear, 7 direction-write) |
| acc_data | input | WIDTH | Write data, bit mask or direction vector |
| pad_in | input | WIDTH | Pin input values |
| pad_out | output | WIDTH | Output latch to the pad drivers |
| pad_oe | output | WIDTH | Per-pin output enable |
| rd_data | output | WIDTH | Last read result |
| test_flag | output | 1 | Last test result |

## Verification
A corrupted direction register shows up at pad_oe one edge after the access that should have set it. In the auto variant it can also show as a split enable pattern, which no correct state can produce. A wrong latch update shows at pad_out in the cycle after the write-type access, even while the drivers are off. An input-path fault stays hidden until the next read or test and then shows one edge later on rd_data or test_flag. For that reason the sweeps follow every pin pattern with reads and tests across all masks. Standby faults show at pad_oe in the same cycle and at the first access made under standby.

// File: rtl/adp_pkg.sv
package adp_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_READ  = 3'd1,
        OP_TSTS  = 3'd2,
        OP_TSTC  = 3'd3,
        OP_WRITE = 3'd4,
        OP_SETB  = 3'd5,
        OP_CLRB  = 3'd6,
        OP_DIRW  = 3'd7
    } adp_op_e;

    typedef struct packed {
        logic is_read;
        logic is_tsts;
        logic is_tstc;
        logic is_write;
        logic is_setb;
        logic is_clrb;
        logic is_dirw;
    } adp_cmd_t;
endpackage

// File: rtl/adp_decode.sv
module adp_decode
    import adp_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] op,
    output adp_cmd_t   cmd,
    output logic       in_access,
    output logic       out_access
);
    always_comb begin
        cmd          = '0;
        cmd.is_read  = valid && (op == OP_READ);
        cmd.is_tsts  = valid && (op == OP_TSTS);
        cmd.is_tstc  = valid && (op == OP_TSTC);
        cmd.is_write = valid && (op == OP_WRITE);
        cmd.is_setb  = valid && (op == OP_SETB);
        cmd.is_clrb  = valid && (op == OP_CLRB);
        cmd.is_dirw  = valid && (op == OP_DIRW);
        in_access    = cmd.is_read || cmd.is_tsts || cmd.is_tstc;
        out_access   = cmd.is_write || cmd.is_setb || cmd.is_clrb;
    end
endmodule

// File: rtl/adp_latch_next.sv
module adp_latch_next
    import adp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  adp_cmd_t           cmd,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   data,
    output logic [WIDTH-1:0]   nxt
);
    always_comb begin
        nxt = cur;
        if (cmd.is_write) begin
            nxt = data;
        end else if (cmd.is_setb) begin
            nxt = cur | data;
        end else if (cmd.is_clrb) begin
            nxt = cur & ~data;
        end
    end
endmodule

// File: rtl/adp_dir_next.sv
module adp_dir_next #(
    parameter int WIDTH   = 4,
    parameter bit PER_PIN = 1'b0
) (
    input  logic             in_access,
    input  logic             out_access,
    input  logic             dir_write,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] nxt
);
    generate
        if (PER_PIN) begin : g_per_pin
            logic unused_pp;
            assign unused_pp = in_access ^ out_access;
            always_comb begin
                nxt = cur;
                if (dir_write) begin
                    nxt = data;
                end
            end
        end else begin : g_auto
            logic unused_auto;
            assign unused_auto = dir_write ^ (^data);
            always_comb begin
                nxt = cur;
                if (in_access) begin
                    nxt = '0;
                end else if (out_access) begin
                    nxt = '1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/adp_sample.sv
module adp_sample #(
    parameter int WIDTH = 4
) (
    input  logic             standby,
    input  logic [WIDTH-1:0] pad_in,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] qual,
    output logic             all_set,
    output logic             all_clear
);
    always_comb begin
        qual      = standby ? '0 : pad_in;
        all_set   = &(~mask | qual);
        all_clear = &(~mask | ~qual);
    end
endmodule

// File: rtl/auto_dir_port.sv
module auto_dir_port
    import adp_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter bit PER_PIN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             acc_valid,
    input  logic [2:0]       acc_op,
    input  logic [WIDTH-1:0] acc_data,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] rd_data,
    output logic             test_flag
);
    localparam logic [WIDTH-1:0] ALL_OUT = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] rd;
        logic             flag;
    } port_state_t;

    port_state_t state_d, state_q;

    adp_cmd_t         cmd;
    logic             in_access, out_access;
    logic [WIDTH-1:0] latch_nxt, dir_nxt, qual;
    logic             all_set, all_clear;

    adp_decode u_decode (
        .valid      (acc_valid),
        .op         (acc_op),
        .cmd        (cmd),
        .in_access  (in_access),
        .out_access (out_access)
    );

    adp_latch_next #(.WIDTH(WIDTH)) u_latch (
        .cmd  (cmd),
        .cur  (state_q.latch),
        .data (acc_data),
        .nxt  (latch_nxt)
    );

    adp_dir_next #(.WIDTH(WIDTH), .PER_PIN(PER_PIN)) u_dir (
        .in_access  (in_access),
        .out_access (out_access),
        .dir_write  (cmd.is_dirw),
        .cur        (state_q.dir),
        .data       (acc_data),
        .nxt        (dir_nxt)
    );

    adp_sample #(.WIDTH(WIDTH)) u_sample (
        .standby   (standby),
        .pad_in    (pad_in),
        .mask      (acc_data),
        .qual      (qual),
        .all_set   (all_set),
        .all_clear (all_clear)
    );

    always_comb begin
        state_d       = state_q;
        state_d.latch = latch_nxt;
        state_d.dir   = dir_nxt;
        if (cmd.is_read) begin
            state_d.rd = qual;
        end
        if (cmd.is_tsts) begin
            state_d.flag = all_set;
        end else if (cmd.is_tstc) begin
            state_d.flag = all_clear;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pad_out   = state_q.latch;
    assign pad_oe    = standby ? '0 : state_q.dir;
    assign rd_data   = state_q.rd;
    assign test_flag = state_q.flag;

    p_latch_held_on_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_access |=> $stable(pad_out));

    p_write_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.is_write |=> (pad_out == $past(acc_data)));

    p_set_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.is_setb |=> ((pad_out & $past(acc_data)) == $past(acc_data)));

    p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.is_clrb |=> ((pad_out & $past(acc_data)) == '0));

    p_standby_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (pad_oe == '0));

    p_standby_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.is_read && standby) |=> (rd_data == '0));

    generate
        if (!PER_PIN) begin : g_auto_checks
            p_input_turnaround_r2: assert property (@(posedge clk) disable iff (!rst_n)
                in_access |=> (state_q.dir == '0));

            p_output_turnaround_r3: assert property (@(posedge clk) disable iff (!rst_n)
                out_access |=> (state_q.dir == ALL_OUT));

            p_uniform_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (pad_oe == '0) || (pad_oe == ALL_OUT));
        end else begin : g_pp_checks
            p_dir_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
                cmd.is_dirw |=> (state_q.dir == $past(acc_data)));

            p_dir_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_access || out_access) |=> $stable(state_q.dir));
        end
    endgenerate
endmodule

// File: tb/tb_auto_dir_port.sv
`timescale 1ns/1ps
module tb_auto_dir_port;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         standby;
    logic         acc_valid;
    logic [2:0]   acc_op;
    logic [W-1:0] acc_data;
    logic [W-1:0] pad_in;

    logic [W-1:0] out_a, oe_a, rd_a, out_p, oe_p, rd_p;
    logic         flag_a, flag_p;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] m_lat, m_dir_a, m_dir_p, m_rd;
    logic         m_flag;

    always #2.5 clk = ~clk;

    auto_dir_port #(.WIDTH(W), .PER_PIN(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .acc_valid(acc_valid),
        .acc_op(acc_op), .acc_data(acc_data), .pad_in(pad_in),
        .pad_out(out_a), .pad_oe(oe_a), .rd_data(rd_a), .test_flag(flag_a));

    auto_dir_port #(.WIDTH(W), .PER_PIN(1'b1)) dut_pp (
        .clk(clk), .rst_n(rst_n), .standby(standby), .acc_valid(acc_valid),
        .acc_op(acc_op), .acc_data(acc_data), .pad_in(pad_in),
        .pad_out(out_p), .pad_oe(oe_p), .rd_data(rd_p), .test_flag(flag_p));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic [W-1:0] ea, ep;
        ea = standby ? '0 : m_dir_a;
        ep = standby ? '0 : m_dir_p;
        chk(out_a == m_lat, {req, " pad_out auto"}, int'(out_a), int'(m_lat));
        chk(out_p == m_lat, {req, " pad_out per-pin"}, int'(out_p), int'(m_lat));
        chk(oe_a == ea, {req, " pad_oe auto"}, int'(oe_a), int'(ea));
        chk(oe_p == ep, {req, " pad_oe per-pin"}, int'(oe_p), int'(ep));
        chk(rd_a == m_rd && rd_p == m_rd, {req, " rd_data"}, int'(rd_a), int'(m_rd));
        chk(flag_a == m_flag && flag_p == m_flag, {req, " test_flag"},
            int'(flag_a), int'(m_flag));
    endtask

    task automatic do_op(input int op, input int d, input string req);
        logic [W-1:0] q, m;
        @(negedge clk);
        acc_valid = 1'b1;
        acc_op    = 3'(op);
        acc_data  = W'(d);
        m = W'(d);
        q = standby ? '0 : pad_in;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_op    = 3'd0;
        case (op)
            1: begin m_rd = q; m_dir_a = '0; end
            2: begin m_flag = ((q & m) == m); m_dir_a = '0; end
            3: begin m_flag = ((q & m) == '0); m_dir_a = '0; end
            4: begin m_lat = m; m_dir_a = '1; end
            5: begin m_lat = m_lat | m; m_dir_a = '1; end
            6: begin m_lat = m_lat & ~m; m_dir_a = '1; end
            7: m_dir_p = m;
            default: ;
        endcase
        check_all(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; standby = 1'b0; acc_valid = 1'b0; acc_op = 3'd0;
        acc_data = '0; pad_in = '0;
        m_lat = '0; m_dir_a = '0; m_dir_p = '0; m_rd = '0; m_flag = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // R3 R4: full writes over every value, then R2 read turnaround
        for (int v = 0; v < 16; v++) begin
            do_op(4, v, "R3 R4 write");
            pad_in = W'(15 - v);
            do_op(1, 0, "R2 R7 read");
        end

        // R4: bit-set and bit-clear across every latch value and mask
        for (int b = 0; b < 16; b++) begin
            for (int m = 0; m < 16; m++) begin
                do_op(4, b, "R4 base write");
                do_op(5, m, "R4 R3 bit-set");
                do_op(4, b, "R4 base write");
                do_op(6, m, "R4 R3 bit-clear");
            end
        end

        // R8: test-set and test-clear across every pin pattern and mask
        for (int p = 0; p < 16; p++) begin
            pad_in = W'(p);
            for (int m = 0; m < 16; m++) begin
                do_op(2, m, "R8 R2 test-set");
                do_op(3, m, "R8 R2 test-clear");
            end
            do_op(1, 0, "R7 read sweep");
            do_op(5, 0, "R7 rd_data held");
        end

        // R5 R6: direction writes
        do_op(4, 9, "R3 prep output");
        for (int d = 0; d < 16; d++) begin
            do_op(7, d, "R6 R5 direction write");
            do_op(4, 15 - d, "R6 write keeps direction");
            do_op(1, 0, "R6 read keeps direction");
        end

        // R9 R10: standby
        do_op(7, 4'b1010, "R6 dir prep");
        do_op(4, 4'b0110, "R3 prep");
        pad_in = 4'hF;
        @(negedge clk);
        standby = 1'b1;
        #1;
        check_all("R9 standby drivers off");
        do_op(1, 0, "R10 standby read zero");
        do_op(2, 4'hF, "R10 standby test-set");
        do_op(3, 4'hF, "R10 standby test-clear");
        do_op(5, 4'b1000, "R9 latch update under standby");
        @(negedge clk);
        standby = 1'b0;
        #1;
        check_all("R9 enables restored");
        do_op(1, 0, "R10 read after standby");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule